// File: doc/BRIEF.md
# Dual-Slope Measurement Interval Sequencer

This block steps an integrating analog-to-digital converter through its measurement cycle and turns the current interval into the four analog switch controls. The cycle runs through auto-zero, run-up (signal integration), run-down (reference de-integration), overrange and overflow, and then returns to auto-zero. Internal counters never set how long an interval lasts. The counting logic ends an interval by raising an advance strobe. A comparator zero-detect flag ends the de-integrating intervals early.

All state changes wait for the slow timing tick (a 100 kHz enable on the system clock). The switch controls are a combinational decode of the interval, the polarity held in a register and the live zero-detect flag. The auto-zero loop is closed in every interval except run-up and run-down. While it is closed, the input amplifier is held on ground. During run-down, exactly one reference switch is enabled. The polarity sampled at the start of run-down chooses which one.

Top module: `dsq_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is auto-zero. The outputs then read `phase`=0, `az_close`=1, `amp_en`=0, `ref_p_en`=0 and `ref_n_en`=0.
- R2: A clock edge with `tick`=1 and `adv`=1 moves the interval along a fixed order. The codes are auto-zero (0), run-up (1), run-down (2), overrange (3) and overflow (4), and overflow moves back to auto-zero (0).
- R3: A clock edge with `tick`=0, or with `adv`=0 and no zero-detect return, leaves `phase` unchanged.
- R4: In run-down, overrange or overflow, an edge with `tick`=1 and `zdet`=1 returns `phase` to 0. This takes priority over `adv`.
- R5: In auto-zero and run-up, `zdet` has no effect on `phase` or on the switch outputs.
- R6: `az_close` is 0 exactly in run-up and run-down and 1 in every other interval. `amp_en` is always the inverse of `az_close`.
- R7: In run-down with `zdet`=0, exactly one reference switch is on. `ref_p_en` is on when the stored polarity is 0 and `ref_n_en` is on when it is 1.
- R8: The stored polarity is sampled from `pol_neg` only on the edge that moves run-up to run-down. Later changes on `pol_neg` do not alter the reference selection.
- R9: Both reference switches are off outside run-down, and also in run-down while `zdet`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | 100 kHz timing enable, one clock wide |
| adv | input | 1 | Interval advance strobe from the counting logic |
| pol_neg | input | 1 | Comparator polarity (1 = negative input) |
| zdet | input | 1 | Comparator zero-detect flag |
| phase | output | 3 | Current interval code |
| amp_en | output | 1 | Connect input amplifier to the signal |
| az_close | output | 1 | Close auto-zero loop, ground amplifier input |
| ref_p_en | output | 1 | Reference switch used for positive inputs |
| ref_n_en | output | 1 | Reference switch used for negative inputs |

## Verification
The assertions assume that `phase` only ever holds one of the five defined codes. They also assume that `tick`, `adv` and `zdet` are plain levels sampled at the clock, with no relation required between them. The stimulus drives every input on the falling edge and holds it for one full cycle. It mixes `tick`-gated and ungated strobes and raises zero-detect in every interval. It also toggles `pol_neg` after run-down has begun, so the priority and sampling rules are exercised without a multi-cycle input protocol.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

    localparam int PHASE_W = 3;

    typedef enum logic [PHASE_W-1:0] {
        PH_ZERO  = 3'd0,
        PH_INTEG = 3'd1,
        PH_DEINT = 3'd2,
        PH_OVRNG = 3'd3,
        PH_OVFL  = 3'd4
    } phase_e;

    typedef struct packed {
        logic amp_en;
        logic az_close;
        logic ref_p_en;
        logic ref_n_en;
    } sw_ctrl_t;

    function automatic phase_e phase_after(input phase_e cur);
        case (cur)
            PH_ZERO:  return PH_INTEG;
            PH_INTEG: return PH_DEINT;
            PH_DEINT: return PH_OVRNG;
            PH_OVRNG: return PH_OVFL;
            default:  return PH_ZERO;
        endcase
    endfunction

    function automatic logic watches_zero(input phase_e cur);
        return (cur == PH_DEINT) || (cur == PH_OVRNG) || (cur == PH_OVFL);
    endfunction

    function automatic logic loop_open(input phase_e cur);
        return (cur == PH_INTEG) || (cur == PH_DEINT);
    endfunction

endpackage

// File: rtl/dsq_step.sv
module dsq_step
    import dsq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   adv,
    input  logic   zdet,
    output phase_e cur,
    output logic   enter_deint
);

    phase_e nxt;
    logic   zero_ret;
    logic   step_on;

    always_comb begin
        zero_ret    = tick && zdet && watches_zero(cur);
        step_on     = tick && adv;
        enter_deint = step_on && !zero_ret && (cur == PH_INTEG);
        nxt         = cur;
        if (zero_ret)
            nxt = PH_ZERO;
        else if (step_on)
            nxt = phase_after(cur);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur <= PH_ZERO;
        else
            cur <= nxt;
    end

    // R3
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cur));

    // R4
    zero_return_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && zdet && (cur inside {PH_DEINT, PH_OVRNG, PH_OVFL})) |=> (cur == PH_ZERO));

    // R2
    order_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && adv && cur == PH_ZERO) |=> (cur == PH_INTEG));

    // R5
    zdet_early_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !adv && cur == PH_INTEG) |=> (cur == PH_INTEG));

endmodule

// File: rtl/dsq_pol.sv
module dsq_pol (
    input  logic clk,
    input  logic rst,
    input  logic capture,
    input  logic pol_in,
    output logic pol_q
);

    always_ff @(posedge clk) begin
        if (rst)
            pol_q <= 1'b0;
        else if (capture)
            pol_q <= pol_in;
    end

    // R8
    pol_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(pol_q));

endmodule

// File: rtl/dsq_decode.sv
module dsq_decode
    import dsq_pkg::*;
(
    input  phase_e   cur,
    input  logic     pol_q,
    input  logic     zdet,
    output sw_ctrl_t sw
);

    logic ref_live;

    always_comb begin
        ref_live    = (cur == PH_DEINT) && !zdet;
        sw.az_close = !loop_open(cur);
        sw.amp_en   = loop_open(cur);
        sw.ref_p_en = ref_live && !pol_q;
        sw.ref_n_en = ref_live && pol_q;
    end

    // R7
    always_comb ref_excl_chk: assert ($onehot0({sw.ref_p_en, sw.ref_n_en}));

    // R6
    always_comb amp_az_chk: assert (sw.amp_en != sw.az_close);

endmodule

// File: rtl/dsq_sequencer.sv
module dsq_sequencer
    import dsq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               adv,
    input  logic               pol_neg,
    input  logic               zdet,
    output logic [PHASE_W-1:0] phase,
    output logic               amp_en,
    output logic               az_close,
    output logic               ref_p_en,
    output logic               ref_n_en
);

    phase_e   cur;
    logic     enter_deint;
    logic     pol_q;
    sw_ctrl_t sw;

    dsq_step u_step (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .adv         (adv),
        .zdet        (zdet),
        .cur         (cur),
        .enter_deint (enter_deint)
    );

    dsq_pol u_pol (
        .clk     (clk),
        .rst     (rst),
        .capture (enter_deint),
        .pol_in  (pol_neg),
        .pol_q   (pol_q)
    );

    dsq_decode u_dec (
        .cur   (cur),
        .pol_q (pol_q),
        .zdet  (zdet),
        .sw    (sw)
    );

    assign phase    = cur;
    assign amp_en   = sw.amp_en;
    assign az_close = sw.az_close;
    assign ref_p_en = sw.ref_p_en;
    assign ref_n_en = sw.ref_n_en;

    // R9
    ref_outside_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != 3'd2) |-> !(ref_p_en || ref_n_en));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (phase == 3'd0));

endmodule

// File: tb/sim_dsq_sequencer.sv
module sim_dsq_sequencer;

    logic       clk = 1'b0;
    logic       rst, tick, adv, pol_neg, zdet;
    logic [2:0] phase;
    logic       amp_en, az_close, ref_p_en, ref_n_en;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [6:0] exp_q [$];
    string      req_q [$];

    int m_ph  = 0;
    bit m_pol = 0;

    always #4 clk = ~clk;

    dsq_sequencer u0 (
        .clk(clk), .rst(rst), .tick(tick), .adv(adv), .pol_neg(pol_neg), .zdet(zdet),
        .phase(phase), .amp_en(amp_en), .az_close(az_close),
        .ref_p_en(ref_p_en), .ref_n_en(ref_n_en)
    );

    task automatic check(input bit ok, input string req, input logic [6:0] got, input logic [6:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    // one cycle of stimulus; model computes the expected post-edge outputs
    task automatic drive(input bit t, input bit a, input bit p, input bit z, input string req);
        bit open, live;
        @(negedge clk);
        tick = t; adv = a; pol_neg = p; zdet = z;
        if (t && z && m_ph >= 2)
            m_ph = 0;
        else if (t && a) begin
            if (m_ph == 1) m_pol = p;
            m_ph = (m_ph == 4) ? 0 : m_ph + 1;
        end
        open = (m_ph == 1) || (m_ph == 2);
        live = (m_ph == 2) && !z;
        exp_q.push_back({m_ph[2:0], open, !open, live && !m_pol, live && m_pol});
        req_q.push_back(req);
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [6:0] e;
                logic [6:0] g;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                g = {phase, amp_en, az_close, ref_p_en, ref_n_en};
                check(g === e, r, g, e);
            end
        end
    end

    initial begin : watchdog
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        rst = 1; tick = 0; adv = 0; pol_neg = 0; zdet = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check({phase, amp_en, az_close, ref_p_en, ref_n_en} === 7'b000_0100, "R1",
              {phase, amp_en, az_close, ref_p_en, ref_n_en}, 7'b000_0100);
        rst = 0;
        // R3 adv without tick, tick without adv
        drive(0, 1, 0, 0, "R3");
        drive(1, 0, 0, 0, "R3");
        // R5 zdet in auto-zero ignored
        drive(1, 0, 0, 1, "R5");
        // R2 to run-up
        drive(1, 1, 0, 0, "R2");
        // R5 zdet in run-up ignored, R6 loop open
        drive(1, 0, 1, 1, "R5");
        drive(0, 0, 0, 0, "R6");
        // R7/R8 enter run-down with positive polarity
        drive(1, 1, 0, 0, "R7");
        drive(0, 0, 1, 0, "R8");
        drive(1, 0, 1, 0, "R8");
        // R9 zdet without tick drops refs but stays
        drive(0, 0, 0, 1, "R9");
        // R2 through overrange and overflow back to zero
        drive(1, 1, 0, 0, "R2");
        drive(1, 1, 0, 0, "R2");
        drive(1, 1, 0, 0, "R2");
        // negative polarity pass, R4 in run-down with adv priority
        drive(1, 1, 1, 0, "R2");
        drive(1, 1, 1, 0, "R7");
        drive(0, 0, 0, 0, "R8");
        drive(1, 1, 0, 1, "R4");
        // R4 in overrange
        drive(1, 1, 0, 0, "R2");
        drive(1, 1, 0, 0, "R2");
        drive(1, 1, 0, 0, "R9");
        drive(1, 0, 0, 1, "R4");
        // R4 in overflow
        drive(1, 1, 0, 0, "R2");
        drive(1, 1, 1, 0, "R2");
        drive(1, 1, 0, 0, "R2");
        drive(1, 1, 0, 0, "R9");
        drive(0, 1, 0, 1, "R3");
        drive(1, 1, 0, 1, "R4");
        // R1 reset mid run-down
        drive(1, 1, 0, 0, "R2");
        drive(1, 1, 1, 0, "R7");
        repeat (2) @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        check({phase, amp_en, az_close, ref_p_en, ref_n_en} === 7'b000_0100, "R1",
              {phase, amp_en, az_close, ref_p_en, ref_n_en}, 7'b000_0100);
        repeat (2) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule